// File: doc/BRIEF.md
# Dual-Path Prioritized Bus Crossbar

This block is a shared bus interconnect with eight initiator ports and nine target ports, using classic cycle/strobe/acknowledge handshaking. Each initiator's upper address byte selects a target. Target 0 has its own arbitrated path. Targets 1 to 8 share a second arbitrated path. Because the two paths are independent, a long run of traffic to target 0 never stalls work aimed at the other targets.

Each path grants by a fixed order in which the lowest initiator index wins. A grant lasts as long as the owner keeps requesting that path. Address, write data, byte selects and write enable flow from the granted initiator to the decoded target. Acknowledge and read data flow back only to that initiator. A request whose address hits no window is never forwarded, and it is never acknowledged.

Top module: `dualPathXbar`

## Requirements
- R1: Address bits [31:24] select the target: 0x00 selects target 0, 0x04 target 1, 0x97 target 2, 0x92 target 3, 0x9D target 4, 0x90 target 5, 0x94 target 6, 0x9E target 7 and 0x9F target 8. Only the selected target sees its cycle and strobe asserted.
- R2: When several initiators request the same path in one cycle and the path is free, the initiator with the lowest index is granted.
- R3: Once granted, an initiator keeps the path on every following cycle in which it still requests that path, even if a higher priority initiator starts requesting.
- R4: A transfer to target 0 and a transfer to any of targets 1 to 8 by different initiators proceed in the same cycle, and both are acknowledged.
- R5: A target's acknowledge and read data reach only the initiator granted on that path. All other initiators see acknowledge low and read data zero.
- R6: An address whose top byte matches no window asserts no target cycle and returns no acknowledge.
- R7: Each path grants at most one initiator, and no initiator holds both paths at once.
- R8: Address, write data, byte select and write enable of the granted initiator appear unchanged on the selected target's port in the same cycle.
- R9: With reset asserted and no requests, all target cycles, strobes and initiator acknowledges are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| iCyc | input | 8 | Initiator bus cycle request, one bit per initiator |
| iStb | input | 8 | Initiator transfer strobe |
| iWe | input | 8 | Initiator write enable |
| iAdr | input | 256 | Initiator addresses, 32 bits each, initiator n at [32n+31:32n] |
| iDatW | input | 256 | Initiator write data, 32 bits each |
| iSel | input | 32 | Initiator byte selects, 4 bits each |
| iDatR | output | 256 | Read data returned to each initiator |
| iAck | output | 8 | Acknowledge returned to each initiator |
| tCyc | output | 9 | Target bus cycle, one bit per target |
| tStb | output | 9 | Target transfer strobe |
| tWe | output | 9 | Target write enable |
| tAdr | output | 288 | Address forwarded to each target |
| tDatW | output | 288 | Write data forwarded to each target |
| tSel | output | 36 | Byte selects forwarded to each target |
| tDatR | input | 288 | Read data from each target |
| tAck | input | 9 | Acknowledge from each target |

## Verification
Errors in the arbiter state show up at the acknowledge outputs. A stale or lost owner register hands the acknowledge to the wrong initiator on the cycle right after a competing request appears. A broken priority pick shows up in the same cycle as a simultaneous request. Decode or target-select faults show up at once, as a cycle asserted on the wrong target or as read data from the wrong target. A coupling between the two paths shows up as a missing acknowledge on one path while the other path is busy.

// File: rtl/xbarPkg.sv
package xbarPkg;
  localparam int NUM_INIT = 8;
  localparam int NUM_TGT  = 9;

  // Window select byte for each target, index = target number
  localparam logic [7:0] TGT_TOP [NUM_TGT] =
    '{8'h00, 8'h04, 8'h97, 8'h92, 8'h9D, 8'h90, 8'h94, 8'h9E, 8'h9F};

  typedef struct packed {
    logic [NUM_INIT-1:0] gnt0;    // owner of the target-0 path
    logic [NUM_INIT-1:0] gnt1;    // owner of the shared path
    logic [NUM_TGT-1:0]  tgtSel1; // one-hot target on the shared path (bit 0 unused)
    logic                act0;
    logic                act1;
  } xbarCtl_t;

  function automatic logic [NUM_TGT-1:0] decodeTop(input logic [7:0] top);
    logic [NUM_TGT-1:0] hit;
    for (int k = 0; k < NUM_TGT; k++) hit[k] = (top == TGT_TOP[k]);
    return hit;
  endfunction
endpackage

// File: rtl/prioArbiter.sv
module prioArbiter #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic [N-1:0] owner;
  logic [N-1:0] pick;
  logic         keep;

  always_comb begin
    pick = req & (~req + N'(1));  // lowest index wins
    keep = |(owner & req);
    gnt  = keep ? owner : pick;
  end

  always_ff @(posedge clk) begin
    if (!rstN) owner <= '0;
    else       owner <= gnt;
  end
endmodule

// File: rtl/xbarControl.sv
module xbarControl
  import xbarPkg::*;
#(
  parameter int AW = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_INIT-1:0]    iCyc,
  input  logic [NUM_INIT*AW-1:0] iAdr,
  output logic [NUM_INIT-1:0]    req0,
  output logic [NUM_INIT-1:0]    req1,
  output xbarCtl_t               ctl
);
  logic [NUM_TGT-1:0]  hit [NUM_INIT];
  logic [NUM_INIT-1:0] reqP [2];
  logic [NUM_INIT-1:0] gntP [2];

  always_comb begin
    for (int i = 0; i < NUM_INIT; i++) begin
      hit[i]  = decodeTop(iAdr[i*AW+AW-8 +: 8]);
      req0[i] = iCyc[i] & hit[i][0];
      req1[i] = iCyc[i] & (|hit[i][NUM_TGT-1:1]);
    end
    reqP[0] = req0;
    reqP[1] = req1;
  end

  for (genvar p = 0; p < 2; p++) begin : gArb
    prioArbiter #(.N(NUM_INIT)) uArb (
      .clk(clk), .rstN(rstN), .req(reqP[p]), .gnt(gntP[p])
    );
  end

  always_comb begin
    ctl.gnt0    = gntP[0];
    ctl.gnt1    = gntP[1];
    ctl.act0    = |gntP[0];
    ctl.act1    = |gntP[1];
    ctl.tgtSel1 = '0;
    for (int i = 0; i < NUM_INIT; i++)
      if (gntP[1][i]) ctl.tgtSel1 = ctl.tgtSel1 | {hit[i][NUM_TGT-1:1], 1'b0};
  end
endmodule

// File: rtl/xbarDatapath.sv
module xbarDatapath
  import xbarPkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int SW = DW / 8
) (
  input  xbarCtl_t               ctl,
  input  logic [NUM_INIT-1:0]    iStb,
  input  logic [NUM_INIT-1:0]    iWe,
  input  logic [NUM_INIT*AW-1:0] iAdr,
  input  logic [NUM_INIT*DW-1:0] iDatW,
  input  logic [NUM_INIT*SW-1:0] iSel,
  output logic [NUM_INIT*DW-1:0] iDatR,
  output logic [NUM_INIT-1:0]    iAck,
  output logic [NUM_TGT-1:0]     tCyc,
  output logic [NUM_TGT-1:0]     tStb,
  output logic [NUM_TGT-1:0]     tWe,
  output logic [NUM_TGT*AW-1:0]  tAdr,
  output logic [NUM_TGT*DW-1:0]  tDatW,
  output logic [NUM_TGT*SW-1:0]  tSel,
  input  logic [NUM_TGT*DW-1:0]  tDatR,
  input  logic [NUM_TGT-1:0]     tAck
);
  logic [NUM_INIT-1:0] gnt  [2];
  logic [AW-1:0]       adrP [2];
  logic [DW-1:0]       datP [2];
  logic [SW-1:0]       selP [2];
  logic                stbP [2];
  logic                weP  [2];
  logic                ackP [2];
  logic [DW-1:0]       rdP  [2];

  always_comb begin
    gnt[0] = ctl.gnt0;
    gnt[1] = ctl.gnt1;
    for (int p = 0; p < 2; p++) begin
      adrP[p] = '0; datP[p] = '0; selP[p] = '0; stbP[p] = 1'b0; weP[p] = 1'b0;
      for (int i = 0; i < NUM_INIT; i++) begin
        if (gnt[p][i]) begin
          adrP[p] = adrP[p] | iAdr[i*AW +: AW];
          datP[p] = datP[p] | iDatW[i*DW +: DW];
          selP[p] = selP[p] | iSel[i*SW +: SW];
          stbP[p] = stbP[p] | iStb[i];
          weP[p]  = weP[p]  | iWe[i];
        end
      end
    end
  end

  always_comb begin
    for (int k = 0; k < NUM_TGT; k++) begin
      int p;
      p = (k == 0) ? 0 : 1;
      tCyc[k]            = (k == 0) ? ctl.act0 : ctl.tgtSel1[k];
      tStb[k]            = tCyc[k] & stbP[p];
      tWe[k]             = weP[p];
      tAdr[k*AW +: AW]   = adrP[p];
      tDatW[k*DW +: DW]  = datP[p];
      tSel[k*SW +: SW]   = selP[p];
    end
  end

  always_comb begin
    ackP[0] = ctl.act0 & tAck[0];
    rdP[0]  = tDatR[0 +: DW];
    ackP[1] = |(tAck & ctl.tgtSel1);
    rdP[1]  = '0;
    for (int k = 1; k < NUM_TGT; k++)
      if (ctl.tgtSel1[k]) rdP[1] = rdP[1] | tDatR[k*DW +: DW];
    for (int i = 0; i < NUM_INIT; i++) begin
      iAck[i] = (gnt[0][i] & ackP[0]) | (gnt[1][i] & ackP[1]);
      if (gnt[0][i])      iDatR[i*DW +: DW] = rdP[0];
      else if (gnt[1][i]) iDatR[i*DW +: DW] = rdP[1];
      else                iDatR[i*DW +: DW] = '0;
    end
  end
endmodule

// File: rtl/dualPathXbar.sv
module dualPathXbar
  import xbarPkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int SW = DW / 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_INIT-1:0]    iCyc,
  input  logic [NUM_INIT-1:0]    iStb,
  input  logic [NUM_INIT-1:0]    iWe,
  input  logic [NUM_INIT*AW-1:0] iAdr,
  input  logic [NUM_INIT*DW-1:0] iDatW,
  input  logic [NUM_INIT*SW-1:0] iSel,
  output logic [NUM_INIT*DW-1:0] iDatR,
  output logic [NUM_INIT-1:0]    iAck,
  output logic [NUM_TGT-1:0]     tCyc,
  output logic [NUM_TGT-1:0]     tStb,
  output logic [NUM_TGT-1:0]     tWe,
  output logic [NUM_TGT*AW-1:0]  tAdr,
  output logic [NUM_TGT*DW-1:0]  tDatW,
  output logic [NUM_TGT*SW-1:0]  tSel,
  input  logic [NUM_TGT*DW-1:0]  tDatR,
  input  logic [NUM_TGT-1:0]     tAck
);
  xbarCtl_t            ctl;
  logic [NUM_INIT-1:0] req0;
  logic [NUM_INIT-1:0] req1;

  xbarControl #(.AW(AW)) uCtl (
    .clk(clk), .rstN(rstN), .iCyc(iCyc), .iAdr(iAdr),
    .req0(req0), .req1(req1), .ctl(ctl)
  );

  xbarDatapath #(.AW(AW), .DW(DW)) uDp (
    .ctl(ctl), .iStb(iStb), .iWe(iWe), .iAdr(iAdr), .iDatW(iDatW), .iSel(iSel),
    .iDatR(iDatR), .iAck(iAck), .tCyc(tCyc), .tStb(tStb), .tWe(tWe),
    .tAdr(tAdr), .tDatW(tDatW), .tSel(tSel), .tDatR(tDatR), .tAck(tAck)
  );
endmodule

// File: rtl/dualPathXbarChecker.sv
module dualPathXbarChecker
  import xbarPkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic [NUM_INIT-1:0] iCyc,
  input logic [NUM_INIT-1:0] iAck,
  input logic [NUM_TGT-1:0]  tCyc,
  input logic [NUM_TGT-1:0]  tStb,
  input logic [NUM_INIT-1:0] req0,
  input logic [NUM_INIT-1:0] req1,
  input logic [NUM_INIT-1:0] gnt0,
  input logic [NUM_INIT-1:0] gnt1
);
  assert_single_owner_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(gnt0) && $onehot0(gnt1) && ((gnt0 & gnt1) == '0));

  assert_shared_tgt_onehot_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(tCyc[NUM_TGT-1:1]) && ((tStb & ~tCyc) == '0));

  assert_hold_path0_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && |($past(gnt0) & req0)) |-> (gnt0 == $past(gnt0)));

  assert_hold_path1_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && |($past(gnt1) & req1)) |-> (gnt1 == $past(gnt1)));

  assert_ack_to_owner_R5: assert property (@(posedge clk) disable iff (!rstN)
    (iAck & ~(gnt0 | gnt1)) == '0);

  assert_grant_needs_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((gnt0 & ~req0) == '0) && ((gnt1 & ~req1) == '0));

  assert_no_idle_cycle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (iCyc == '0) |-> (tCyc == '0 && iAck == '0));
endmodule

bind dualPathXbar dualPathXbarChecker uChk (
  .clk(clk), .rstN(rstN), .iCyc(iCyc), .iAck(iAck), .tCyc(tCyc), .tStb(tStb),
  .req0(req0), .req1(req1), .gnt0(ctl.gnt0), .gnt1(ctl.gnt1)
);

// File: tb/tb_dualPathXbar.sv
module tb_dualPathXbar;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 8;
  localparam int NT = 9;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NI-1:0]    iCyc = '0, iStb = '0, iWe = '0;
  logic [NI*AW-1:0] iAdr = '0;
  logic [NI*DW-1:0] iDatW = '0;
  logic [NI*SW-1:0] iSel = '0;
  logic [NI*DW-1:0] iDatR;
  logic [NI-1:0]    iAck;
  logic [NT-1:0]    tCyc, tStb, tWe, tAck;
  logic [NT*AW-1:0] tAdr;
  logic [NT*DW-1:0] tDatW, tDatR;
  logic [NT*SW-1:0] tSel;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  logic [7:0] topByte [NT] = '{8'h00, 8'h04, 8'h97, 8'h92, 8'h9D, 8'h90, 8'h94, 8'h9E, 8'h9F};

  always #(CLK_PERIOD/2) clk = ~clk;

  dualPathXbar dut (.*);

  // Target model: acknowledge on strobe, read data tags the target number
  always_comb begin
    for (int k = 0; k < NT; k++) begin
      tAck[k] = tStb[k];
      tDatR[k*DW +: DW] = {8'hA0 + 8'(k), tAdr[k*AW +: 24]};
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setReq(input int n, input logic [31:0] adr, input bit we, input logic [31:0] dat, input logic [3:0] sel);
    iCyc[n] = 1'b1; iStb[n] = 1'b1; iWe[n] = we;
    iAdr[n*AW +: AW] = adr; iDatW[n*DW +: DW] = dat; iSel[n*SW +: SW] = sel;
  endtask

  task automatic dropReq(input int n);
    iCyc[n] = 1'b0; iStb[n] = 1'b0; iWe[n] = 1'b0;
  endtask

  task automatic idleAll();
    @(negedge clk);
    iCyc = '0; iStb = '0; iWe = '0;
    @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk); #1;
    check(tCyc == '0 && tStb == '0, "R9 target idle in reset", 64'(tCyc), 0);
    check(iAck == '0, "R9 no ack in reset", 64'(iAck), 0);
  endtask

  task automatic testDecode();
    for (int k = 0; k < NT; k++) begin
      logic [31:0] a;
      a = {topByte[k], 24'h001230 + 24'(k)};
      @(negedge clk);
      setReq(7, a, 1'b0, '0, 4'hF);
      #1;
      check(tCyc == NT'(1) << k, "R1 target select", 64'(tCyc), 64'(NT'(1) << k));
      check(iAck[7] && iDatR[7*DW +: DW] == {8'hA0 + 8'(k), a[23:0]}, "R1 read data path",
            64'(iDatR[7*DW +: DW]), 64'({8'hA0 + 8'(k), a[23:0]}));
      idleAll();
    end
  endtask

  task automatic testPriority();
    @(negedge clk);
    setReq(6, 32'h9D000010, 0, '0, 4'hF);
    setReq(2, 32'h9D000020, 0, '0, 4'hF);
    setReq(1, 32'h9D000030, 0, '0, 4'hF);
    setReq(5, 32'h00000040, 0, '0, 4'hF);
    setReq(3, 32'h00000050, 0, '0, 4'hF);
    #1;
    check(iAck == 8'b0000_1010, "R2 lowest index wins per path", 64'(iAck), 64'h0A);
    check(iDatR[2*DW +: DW] == '0 && iDatR[6*DW +: DW] == '0, "R5 losers read zero",
          64'(iDatR[2*DW +: DW]), 0);
    @(negedge clk);
    dropReq(1);
    #1;
    check(iAck == 8'b0000_1100, "R2 next in line after release", 64'(iAck), 64'h0C);
    idleAll();
  endtask

  task automatic testHold();
    @(negedge clk);
    setReq(4, 32'h94000100, 0, '0, 4'hF);
    setReq(6, 32'h00000100, 0, '0, 4'hF);
    @(negedge clk);
    setReq(0, 32'h94000200, 0, '0, 4'hF);
    setReq(1, 32'h00000200, 0, '0, 4'hF);
    #1;
    check(iAck == 8'b0101_0000, "R3 owners keep both paths", 64'(iAck), 64'h50);
    @(negedge clk);
    dropReq(4);
    dropReq(6);
    #1;
    check(iAck == 8'b0000_0011, "R3 higher priority after release", 64'(iAck), 64'h03);
    idleAll();
  endtask

  task automatic testConcurrent();
    @(negedge clk);
    setReq(3, 32'h00000400, 0, '0, 4'hF);
    setReq(5, 32'h97000400, 0, '0, 4'hF);
    #1;
    check(tCyc == 9'b0_0000_0101, "R4 both paths active", 64'(tCyc), 64'h005);
    check(iAck == 8'b0010_1000, "R4 both transfers acknowledged", 64'(iAck), 64'h28);
    check(iDatR[5*DW +: DW] == 32'hA2000400, "R4 shared path read data", 64'(iDatR[5*DW +: DW]), 64'hA2000400);
    idleAll();
  endtask

  task automatic testUnmapped();
    @(negedge clk);
    setReq(2, 32'h50000000, 0, '0, 4'hF);
    setReq(4, 32'h01000000, 0, '0, 4'hF);
    #1;
    check(tCyc == '0, "R6 no target cycle", 64'(tCyc), 0);
    check(iAck == '0, "R6 no acknowledge", 64'(iAck), 0);
    idleAll();
  endtask

  task automatic testForward();
    @(negedge clk);
    setReq(6, 32'h92ABCDEF, 1'b1, 32'h12345678, 4'b0101);
    #1;
    check(tAdr[3*AW +: AW] == 32'h92ABCDEF, "R8 address forwarded", 64'(tAdr[3*AW +: AW]), 64'h92ABCDEF);
    check(tDatW[3*DW +: DW] == 32'h12345678, "R8 write data forwarded", 64'(tDatW[3*DW +: DW]), 64'h12345678);
    check(tSel[3*SW +: SW] == 4'b0101 && tWe[3] && tStb[3], "R8 select, write enable, strobe",
          64'({tSel[3*SW +: SW], tWe[3], tStb[3]}), 64'h17);
    idleAll();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<5000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    testReset();
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testDecode();
    testPriority();
    testHold();
    testConcurrent();
    testUnmapped();
    testForward();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule